// File: doc/BRIEF.md
# Ring Coincidence Pairer

This block pairs single-photon events reported by the detectors of a ring scanner. Each event carries a detector index and a time stamp. The time stamp is a coarse count of sample-clock ticks, with a fine sub-sample offset below it. Two events form a coincidence when the later one comes from a detector inside the earlier one's field of view and their stamps differ by no more than a programmable window. The field of view is the detector diametrically across the ring plus a parameterized number of neighbours on either side of it. The default is two neighbours each side, so five detectors in all.

Two event ports feed the block each cycle. Port A is taken before port B. Events without a partner wait in a small buffer. An event leaves the buffer when it is consumed by a pair, or when a newer stamp has moved more than one window beyond it. Each port has its own output lane. A lane reports the stored (earlier) detector, the new (later) detector and the unsigned stamp difference. Events must be presented in non-decreasing stamp order, with the port A stamp not later than the port B stamp in the same cycle.

Top module: `cpd_coinc`

## Requirements
- R1: After reset both output lanes are invalid and the buffer is empty, so the first event afterwards produces no pair.
- R2: A pair is accepted only if `(second - first + N_DET) mod N_DET` lies in `[N_DET/2 - FOV_SIDE, N_DET/2 + FOV_SIDE]`. This wraps around the ring. For 16 detectors, detector 0 accepts 6..10 and detector 7 accepts 13, 14, 15, 0 and 1.
- R3: A pair is accepted only if the later stamp minus the earlier stamp is at most `win`. A difference of `win` pairs; a difference of `win + 1` does not.
- R4: An event whose time matches a stored event is not paired when the two detectors fail the test of R2.
- R5: A pair found for the port A event appears on lane A, and one for the port B event appears on lane B, one clock after the event is taken. The lane gives first = stored detector, second = new detector, and dt = new stamp minus stored stamp. Stamps are `{coarse, fine}`, with the fine field in the low FINE_W bits.
- R6: When several stored events qualify, the one with the smallest stamp is used; among equal stamps, the lower detector index is used. A stored event that has been used is removed and never pairs again.
- R7: The port B event is checked first against the buffer, then against the port A event of the same cycle. Port A is eligible for this only if it found no partner of its own. A port A event consumed this way is not stored.
- R8: When a new event arrives, every stored event whose stamp is more than `win` behind the newest stamp of that cycle is removed, which frees its place.
- R9: An unpaired event is stored only if a buffer place is free, port A before port B; otherwise it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| win | input | WIN_W | Coincidence window in stamp units |
| a_vld | input | 1 | Port A event valid |
| a_det | input | DETW | Port A detector index |
| a_ts | input | TSW | Port A stamp {coarse, fine} |
| b_vld | input | 1 | Port B event valid |
| b_det | input | DETW | Port B detector index |
| b_ts | input | TSW | Port B stamp {coarse, fine} |
| pa_vld | output | 1 | Lane A pair valid |
| pa_first | output | DETW | Lane A earlier detector |
| pa_second | output | DETW | Lane A later detector |
| pa_dt | output | TSW | Lane A stamp difference |
| pb_vld | output | 1 | Lane B pair valid |
| pb_first | output | DETW | Lane B earlier detector |
| pb_second | output | DETW | Lane B later detector |
| pb_dt | output | TSW | Lane B stamp difference |

## Verification
A pair appears on its lane exactly one clock after the edge that takes the event. The bench drives each event on a falling edge and reads both lanes on the next falling edge, after a single rising edge. Buffer effects (consumption, eviction and the full-buffer discard) take effect at that same edge. They can only show in the pairing of later events, so each such case is checked by the lane result of a follow-up event one cycle later. A bench model of the buffer predicts every lane value, both for directed boundary cases and for seeded random traffic.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
   // default neighbours on each side of the opposite detector
   localparam int unsigned CPD_FOV_SIDE = 2;

   // where the lane B partner came from
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BUF  = 2'd1,
      SRC_PEER = 2'd2
   } cpd_src_e;
endpackage

// File: rtl/cpd_fov.sv
module cpd_fov #(
   parameter int N_DET    = 16,
   parameter int FOV_SIDE = 2,
   parameter int DETW     = $clog2(N_DET)
) (
   input  logic [DETW-1:0] ref_det,
   input  logic [DETW-1:0] cand_det,
   output logic            in_view
);
   localparam int HALF = N_DET / 2;
   localparam bit POW2 = ((N_DET & (N_DET - 1)) == 0);
   localparam logic [DETW:0] LO = (DETW+1)'(HALF - FOV_SIDE);
   localparam logic [DETW:0] HI = (DETW+1)'(HALF + FOV_SIDE);

   logic [DETW-1:0] off;

   generate
      if (POW2) begin : g_pow2
         // ring size equals 2**DETW: modulo is free
         assign off = cand_det - ref_det;
      end else begin : g_gen
         localparam logic [DETW:0] NV = (DETW+1)'(N_DET);
         logic [DETW:0] sum;
         assign sum = {1'b0, cand_det} + NV - {1'b0, ref_det};
         assign off = (sum >= NV) ? DETW'(sum - NV) : DETW'(sum);
      end
   endgenerate

   assign in_view = ({1'b0, off} >= LO) && ({1'b0, off} <= HI);
endmodule

// File: rtl/cpd_match.sv
module cpd_match #(
   parameter int N_DET    = 16,
   parameter int DEPTH    = 8,
   parameter int FOV_SIDE = 2,
   parameter int DETW     = 4,
   parameter int TSW      = 18,
   parameter int WIN_W    = 10,
   parameter int IDXW     = 3
) (
   input  logic [DETW-1:0]             ev_det,
   input  logic [TSW-1:0]              ev_ts,
   input  logic [WIN_W-1:0]            win,
   input  logic [DEPTH-1:0]            slot_vld,
   input  logic [DEPTH-1:0][DETW-1:0]  slot_det,
   input  logic [DEPTH-1:0][TSW-1:0]   slot_ts,
   input  logic [DEPTH-1:0]            mask,
   output logic                        hit,
   output logic [IDXW-1:0]             idx
);
   logic [DEPTH-1:0] cand;
   logic [TSW-1:0]   win_x;

   assign win_x = TSW'(win);

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         logic fov_ok;
         logic [TSW-1:0] gap;
         cpd_fov #(.N_DET(N_DET), .FOV_SIDE(FOV_SIDE), .DETW(DETW)) u_fov (
            .ref_det (slot_det[g]),
            .cand_det(ev_det),
            .in_view (fov_ok)
         );
         assign gap     = ev_ts - slot_ts[g];
         assign cand[g] = slot_vld[g] && !mask[g] && fov_ok &&
                          (ev_ts >= slot_ts[g]) && (gap <= win_x);
      end
   endgenerate

   // earliest stamp wins, ties go to the lower detector index
   logic [TSW-1:0]  best_ts;
   logic [DETW-1:0] best_det;
   always_comb begin
      hit      = 1'b0;
      idx      = '0;
      best_ts  = '0;
      best_det = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (cand[i] && (!hit || (slot_ts[i] < best_ts) ||
                         ((slot_ts[i] == best_ts) && (slot_det[i] < best_det)))) begin
            hit      = 1'b1;
            idx      = IDXW'(i);
            best_ts  = slot_ts[i];
            best_det = slot_det[i];
         end
      end
   end
endmodule

// File: rtl/cpd_alloc.sv
module cpd_alloc #(
   parameter int DEPTH = 8,
   parameter int IDXW  = 3
) (
   input  logic [DEPTH-1:0] free,
   output logic             f0_ok,
   output logic [IDXW-1:0]  f0,
   output logic             f1_ok,
   output logic [IDXW-1:0]  f1
);
   // two lowest free places
   always_comb begin
      f0_ok = 1'b0;
      f1_ok = 1'b0;
      f0    = '0;
      f1    = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (free[i]) begin
            if (!f0_ok) begin
               f0_ok = 1'b1;
               f0    = IDXW'(i);
            end else if (!f1_ok) begin
               f1_ok = 1'b1;
               f1    = IDXW'(i);
            end
         end
      end
   end
endmodule

// File: rtl/cpd_coinc.sv
module cpd_coinc #(
   parameter int N_DET    = 16,
   parameter int DEPTH    = 8,
   parameter int CRS_W    = 12,
   parameter int FINE_W   = 6,
   parameter int WIN_W    = 10,
   parameter int FOV_SIDE = cpd_pkg::CPD_FOV_SIDE,
   parameter int DETW     = $clog2(N_DET),
   parameter int TSW      = CRS_W + FINE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WIN_W-1:0]  win,
   input  logic              a_vld,
   input  logic [DETW-1:0]   a_det,
   input  logic [TSW-1:0]    a_ts,
   input  logic              b_vld,
   input  logic [DETW-1:0]   b_det,
   input  logic [TSW-1:0]    b_ts,
   output logic              pa_vld,
   output logic [DETW-1:0]   pa_first,
   output logic [DETW-1:0]   pa_second,
   output logic [TSW-1:0]    pa_dt,
   output logic              pb_vld,
   output logic [DETW-1:0]   pb_first,
   output logic [DETW-1:0]   pb_second,
   output logic [TSW-1:0]    pb_dt
);
   import cpd_pkg::*;

   localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [DEPTH-1:0] ONE = DEPTH'(1);

   // elaboration-time parameter checks
   generate
      if ((N_DET % 2) != 0) begin : g_bad_odd
         $error("cpd_coinc: N_DET must be even");
      end
      if (N_DET < 2 * FOV_SIDE + 2) begin : g_bad_ring
         $error("cpd_coinc: ring too small for field of view");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("cpd_coinc: DEPTH must be at least 2");
      end
      if (TSW <= WIN_W) begin : g_bad_win
         $error("cpd_coinc: window wider than stamp");
      end
      if (DETW < $clog2(N_DET)) begin : g_bad_detw
         $error("cpd_coinc: DETW too narrow");
      end
   endgenerate

   // buffer of unpaired events
   logic [DEPTH-1:0]           s_vld;
   logic [DEPTH-1:0][DETW-1:0] s_det;
   logic [DEPTH-1:0][TSW-1:0]  s_ts;

   // port A search
   logic            a_hit, a_use;
   logic [IDXW-1:0] a_idx;
   cpd_match #(.N_DET(N_DET), .DEPTH(DEPTH), .FOV_SIDE(FOV_SIDE), .DETW(DETW),
               .TSW(TSW), .WIN_W(WIN_W), .IDXW(IDXW)) u_match_a (
      .ev_det(a_det), .ev_ts(a_ts), .win(win),
      .slot_vld(s_vld), .slot_det(s_det), .slot_ts(s_ts),
      .mask('0), .hit(a_hit), .idx(a_idx)
   );
   assign a_use = a_vld && a_hit;

   // port B search, excluding what A took
   logic [DEPTH-1:0] b_mask;
   logic             b_hit;
   logic [IDXW-1:0]  b_idx;
   assign b_mask = a_use ? (ONE << a_idx) : '0;
   cpd_match #(.N_DET(N_DET), .DEPTH(DEPTH), .FOV_SIDE(FOV_SIDE), .DETW(DETW),
               .TSW(TSW), .WIN_W(WIN_W), .IDXW(IDXW)) u_match_b (
      .ev_det(b_det), .ev_ts(b_ts), .win(win),
      .slot_vld(s_vld), .slot_det(s_det), .slot_ts(s_ts),
      .mask(b_mask), .hit(b_hit), .idx(b_idx)
   );

   // same-cycle A to B pairing
   logic           ab_fov, peer_ok;
   logic [TSW-1:0] ab_gap;
   cpd_fov #(.N_DET(N_DET), .FOV_SIDE(FOV_SIDE), .DETW(DETW)) u_fov_ab (
      .ref_det(a_det), .cand_det(b_det), .in_view(ab_fov)
   );
   assign ab_gap  = b_ts - a_ts;
   assign peer_ok = a_vld && !a_use && ab_fov && (b_ts >= a_ts) &&
                    (ab_gap <= TSW'(win));

   cpd_src_e b_src;
   always_comb begin
      if (!b_vld)      b_src = SRC_NONE;
      else if (b_hit)  b_src = SRC_BUF;
      else if (peer_ok) b_src = SRC_PEER;
      else             b_src = SRC_NONE;
   end

   // eviction against the newest stamp of this cycle
   logic           any_in;
   logic [TSW-1:0] now_ts;
   logic [DEPTH-1:0] keep;
   assign any_in = a_vld || b_vld;
   assign now_ts = b_vld ? b_ts : a_ts;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         keep[i] = s_vld[i]
                   && !(any_in && ((now_ts - s_ts[i]) > TSW'(win)))
                   && !(a_use && (a_idx == IDXW'(i)))
                   && !((b_src == SRC_BUF) && (b_idx == IDXW'(i)));
      end
   end

   // allocation of free places
   logic            f0_ok, f1_ok;
   logic [IDXW-1:0] f0, f1;
   cpd_alloc #(.DEPTH(DEPTH), .IDXW(IDXW)) u_alloc (
      .free(~keep), .f0_ok(f0_ok), .f0(f0), .f1_ok(f1_ok), .f1(f1)
   );

   logic            ins_a, ins_b, wr_a, wr_b;
   logic [IDXW-1:0] slot_a, slot_b;
   assign ins_a  = a_vld && !a_use && (b_src != SRC_PEER);
   assign ins_b  = b_vld && (b_src == SRC_NONE);
   assign wr_a   = ins_a && f0_ok;
   assign slot_a = f0;
   assign wr_b   = ins_b && (ins_a ? f1_ok : f0_ok);
   assign slot_b = ins_a ? f1 : f0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_vld <= '0;
         s_det <= '0;
         s_ts  <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_a && (slot_a == IDXW'(i))) begin
               s_vld[i] <= 1'b1;
               s_det[i] <= a_det;
               s_ts[i]  <= a_ts;
            end else if (wr_b && (slot_b == IDXW'(i))) begin
               s_vld[i] <= 1'b1;
               s_det[i] <= b_det;
               s_ts[i]  <= b_ts;
            end else begin
               s_vld[i] <= keep[i];
            end
         end
      end
   end

   // output lanes, one register stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pa_vld    <= 1'b0;
         pa_first  <= '0;
         pa_second <= '0;
         pa_dt     <= '0;
         pb_vld    <= 1'b0;
         pb_first  <= '0;
         pb_second <= '0;
         pb_dt     <= '0;
      end else begin
         pa_vld    <= a_use;
         pa_first  <= s_det[a_idx];
         pa_second <= a_det;
         pa_dt     <= a_ts - s_ts[a_idx];
         pb_vld    <= (b_src != SRC_NONE);
         pb_second <= b_det;
         if (b_src == SRC_PEER) begin
            pb_first <= a_det;
            pb_dt    <= ab_gap;
         end else begin
            pb_first <= s_det[b_idx];
            pb_dt    <= b_ts - s_ts[b_idx];
         end
      end
   end
endmodule

// File: rtl/cpd_coinc_chk.sv
module cpd_coinc_chk #(
   parameter int N_DET    = 16,
   parameter int FOV_SIDE = 2,
   parameter int DETW     = 4,
   parameter int TSW      = 18,
   parameter int WIN_W    = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIN_W-1:0] win,
   input logic             a_vld,
   input logic             b_vld,
   input logic             pa_vld,
   input logic [DETW-1:0]  pa_first,
   input logic [DETW-1:0]  pa_second,
   input logic [TSW-1:0]   pa_dt,
   input logic             pb_vld,
   input logic [DETW-1:0]  pb_first,
   input logic [DETW-1:0]  pb_second,
   input logic [TSW-1:0]   pb_dt
);
   function automatic bit seen(input int f, input int s);
      int off;
      off = (s - f + N_DET) % N_DET;
      return (off >= N_DET/2 - FOV_SIDE) && (off <= N_DET/2 + FOV_SIDE);
   endfunction

   // R1: no pair in the first cycle out of reset
   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pa_vld && !pb_vld));

   // R2: every reported pair lies in view
   assert_fov_lane_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pa_vld |-> seen(int'(pa_first), int'(pa_second)));
   assert_fov_lane_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pb_vld |-> seen(int'(pb_first), int'(pb_second)));

   // R3: reported differences stay within the window of the taking cycle
   assert_window_lane_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pa_vld |-> (pa_dt <= TSW'($past(win))));
   assert_window_lane_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pb_vld |-> (pb_dt <= TSW'($past(win))));

   // R5: lane A only follows a port A event
   assert_lane_a_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pa_vld |-> $past(a_vld));

   // R7: lane B only follows a port B event
   assert_lane_b_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pb_vld |-> $past(b_vld));
endmodule

bind cpd_coinc cpd_coinc_chk #(
   .N_DET(N_DET), .FOV_SIDE(FOV_SIDE), .DETW(DETW), .TSW(TSW), .WIN_W(WIN_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .win(win), .a_vld(a_vld), .b_vld(b_vld),
   .pa_vld(pa_vld), .pa_first(pa_first), .pa_second(pa_second), .pa_dt(pa_dt),
   .pb_vld(pb_vld), .pb_first(pb_first), .pb_second(pb_second), .pb_dt(pb_dt)
);

// File: tb/cpd_coinc_tb.sv
module cpd_coinc_tb;
   localparam int N_DET = 16;
   localparam int DEPTH = 8;
   localparam int DETW  = 4;
   localparam int TSW   = 18;
   localparam int WIN_W = 10;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [WIN_W-1:0] win = '0;
   logic             a_vld = 1'b0, b_vld = 1'b0;
   logic [DETW-1:0]  a_det = '0, b_det = '0;
   logic [TSW-1:0]   a_ts = '0, b_ts = '0;
   logic             pa_vld, pb_vld;
   logic [DETW-1:0]  pa_first, pa_second, pb_first, pb_second;
   logic [TSW-1:0]   pa_dt, pb_dt;

   always #10ns clk = ~clk;

   cpd_coinc #(.N_DET(N_DET), .DEPTH(DEPTH), .CRS_W(12), .FINE_W(6),
               .WIN_W(WIN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .win(win),
      .a_vld(a_vld), .a_det(a_det), .a_ts(a_ts),
      .b_vld(b_vld), .b_det(b_det), .b_ts(b_ts),
      .pa_vld(pa_vld), .pa_first(pa_first), .pa_second(pa_second), .pa_dt(pa_dt),
      .pb_vld(pb_vld), .pb_first(pb_first), .pb_second(pb_second), .pb_dt(pb_dt)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference buffer, kept in arrival order
   int q_det[DEPTH];
   int q_ts[DEPTH];
   int q_n = 0;
   int e_av, e_af, e_adt, e_bv, e_bf, e_bdt;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit fov(input int f, input int s);
      int off;
      off = (s - f + N_DET) % N_DET;
      return (off >= N_DET/2 - 2) && (off <= N_DET/2 + 2);
   endfunction

   task automatic model(input bit av, input int ad, input int at,
                        input bit bv, input int bd, input int bt, input int w);
      bit rem[DEPTH];
      int k, nd[DEPTH], nt[DEPTH], nn;
      bit peer;
      e_av = 0; e_bv = 0; peer = 0;
      for (int i = 0; i < DEPTH; i++) rem[i] = 0;
      if (av) begin
         k = -1;
         for (int i = 0; i < q_n; i++)
            if (fov(q_det[i], ad) && q_ts[i] <= at && at - q_ts[i] <= w)
               if (k < 0 || q_ts[i] < q_ts[k] || (q_ts[i] == q_ts[k] && q_det[i] < q_det[k])) k = i;
         if (k >= 0) begin e_av = 1; e_af = q_det[k]; e_adt = at - q_ts[k]; rem[k] = 1; end
      end
      if (bv) begin
         k = -1;
         for (int i = 0; i < q_n; i++)
            if (!rem[i] && fov(q_det[i], bd) && q_ts[i] <= bt && bt - q_ts[i] <= w)
               if (k < 0 || q_ts[i] < q_ts[k] || (q_ts[i] == q_ts[k] && q_det[i] < q_det[k])) k = i;
         if (k >= 0) begin e_bv = 1; e_bf = q_det[k]; e_bdt = bt - q_ts[k]; rem[k] = 1; end
         else if (av && !e_av && fov(ad, bd) && bt >= at && bt - at <= w) begin
            e_bv = 1; e_bf = ad; e_bdt = bt - at; peer = 1;
         end
      end
      if (av || bv)
         for (int i = 0; i < q_n; i++)
            if ((bv ? bt : at) - q_ts[i] > w) rem[i] = 1;
      nn = 0;
      for (int i = 0; i < q_n; i++)
         if (!rem[i]) begin nd[nn] = q_det[i]; nt[nn] = q_ts[i]; nn++; end
      if (av && !e_av && !peer && nn < DEPTH) begin nd[nn] = ad; nt[nn] = at; nn++; end
      if (bv && !e_bv && nn < DEPTH) begin nd[nn] = bd; nt[nn] = bt; nn++; end
      for (int i = 0; i < DEPTH; i++) begin q_det[i] = nd[i]; q_ts[i] = nt[i]; end
      q_n = nn;
   endtask

   task automatic step(input bit av, input int ad, input int at,
                       input bit bv, input int bd, input int bt, input string tag);
      a_vld = av; a_det = DETW'(ad); a_ts = TSW'(at);
      b_vld = bv; b_det = DETW'(bd); b_ts = TSW'(bt);
      model(av, ad, at, bv, bd, bt, int'(win));
      @(posedge clk);
      @(negedge clk);
      a_vld = 1'b0; b_vld = 1'b0;
      chk({tag, " lane A valid"}, int'(pa_vld), e_av);
      if (e_av && pa_vld) begin
         chk({tag, " lane A first"}, int'(pa_first), e_af);
         chk({tag, " lane A second"}, int'(pa_second), ad);
         chk({tag, " lane A dt"}, int'(pa_dt), e_adt);
      end
      chk({tag, " lane B valid"}, int'(pb_vld), e_bv);
      if (e_bv && pb_vld) begin
         chk({tag, " lane B first"}, int'(pb_first), e_bf);
         chk({tag, " lane B second"}, int'(pb_second), bd);
         chk({tag, " lane B dt"}, int'(pb_dt), e_bdt);
      end
   endtask

   task automatic ev1(input int d, input int t, input string tag);
      step(1'b1, d, t, 1'b0, 0, t, tag);
   endtask

   initial begin
      #(20ns * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int t;
      void'($urandom(32'd2718));
      win = 10'd20;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset lane A", int'(pa_vld), 0);
      chk("R1 reset lane B", int'(pb_vld), 0);
      t = 100;
      ev1(8, t, "R1 first event");
      chk("R1 no partner after reset", int'(pa_vld), 0);

      // R2 field of view boundaries, with wrap
      t += 200; ev1(0, t, "R2 store"); ev1(6, t + 1, "R2 low edge");
      chk("R2 0->6 pairs", int'(pa_vld), 1);
      t += 200; ev1(0, t, "R2 store"); ev1(10, t + 1, "R2 high edge");
      chk("R2 0->10 pairs", int'(pa_vld), 1);
      t += 200; ev1(0, t, "R4 store"); ev1(11, t, "R4 outside high");
      chk("R4 0->11 rejected", int'(pa_vld), 0);
      t += 200; ev1(0, t, "R4 store"); ev1(5, t, "R4 outside low");
      chk("R4 0->5 rejected", int'(pa_vld), 0);
      t += 200; ev1(7, t, "R2 store"); ev1(1, t + 2, "R2 wrap inside");
      chk("R2 7->1 pairs", int'(pa_vld), 1);
      t += 200; ev1(7, t, "R2 store"); ev1(2, t + 2, "R2 wrap outside");
      chk("R2 7->2 rejected", int'(pa_vld), 0);

      // R3 window edge
      t += 200; ev1(3, t, "R3 store"); ev1(11, t + 20, "R3 at window");
      chk("R3 dt=win pairs", int'(pa_vld), 1);
      chk("R3 dt value", int'(pa_dt), 20);
      t += 200; ev1(3, t, "R3 store"); ev1(11, t + 21, "R3 past window");
      chk("R3 dt=win+1 rejected", int'(pa_vld), 0);

      // R6 earliest partner, consumption, tie
      t += 200; ev1(6, t, "R6 store"); ev1(7, t + 5, "R6 store");
      ev1(14, t + 8, "R6 earliest");
      chk("R6 earliest first", int'(pa_first), 6);
      ev1(14, t + 9, "R6 next");
      chk("R6 used one gone", int'(pa_first), 7);
      ev1(14, t + 10, "R6 none left");
      chk("R6 both used", int'(pa_vld), 0);
      t += 200; ev1(7, t, "R6 tie store"); ev1(5, t, "R6 tie store");
      ev1(14, t + 1, "R6 tie");
      chk("R6 tie lower index", int'(pa_first), 5);

      // R5 both lanes at once; R7 same-cycle pair
      t += 200; ev1(0, t, "R5 store"); ev1(1, t, "R5 store");
      step(1'b1, 8, t + 1, 1'b1, 9, t + 2, "R5 two lanes");
      chk("R5 lane A first", int'(pa_first), 0);
      chk("R5 lane B first", int'(pb_first), 1);
      t += 200; step(1'b1, 2, t, 1'b1, 10, t + 3, "R7 peer");
      chk("R7 lane B valid", int'(pb_vld), 1);
      chk("R7 lane B first", int'(pb_first), 2);
      ev1(10, t + 4, "R7 A not stored");
      chk("R7 consumed A absent", int'(pa_vld), 0);

      // R9 full buffer, R8 eviction frees places
      win = 10'd50;
      t += 1000;
      repeat (4) step(1'b1, 0, t, 1'b1, 0, t, "R9 fill");
      ev1(0, t, "R9 dropped");
      for (int i = 0; i < DEPTH; i++) ev1(8, t + 1, "R9 drain");
      ev1(8, t + 1, "R9 ninth");
      chk("R9 overflow event discarded", int'(pa_vld), 0);
      t += 1000;
      repeat (4) step(1'b1, 0, t, 1'b1, 0, t, "R8 fill");
      ev1(3, t + 60, "R8 evicting event");
      ev1(11, t + 61, "R8 freed place");
      chk("R8 stored after eviction", int'(pa_vld), 1);
      chk("R8 partner", int'(pa_first), 3);

      // seeded random traffic checked against the model
      t += 1000;
      for (int n = 0; n < 1500; n++) begin
         bit av, bv;
         int at, bt;
         if (n % 300 == 0) win = WIN_W'(10 + $urandom % 60);
         av = ($urandom % 10) < 7;
         bv = ($urandom % 10) < 7;
         at = t + int'($urandom % 15);
         bt = at + int'($urandom % 8);
         step(av, int'($urandom % N_DET), at, bv, int'($urandom % N_DET), bt, "R5 random");
         t = bt;
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule